// File: doc/BRIEF.md
# Filtered Set-Associative Way Lookup

This block answers tag lookups for a set-associative array while keeping the number of full-width tag comparisons as low as possible. It holds the tags and valid bits of every line and, beside them, one counting membership filter per way. A lookup first asks each way's filter whether the tag could be present. Any way whose filter counter reads zero is dropped. The remaining ways then compare only the four lowest tag bits. In the second cycle the full 20-bit comparators are enabled only for the ways that passed both screens, and the block reports hit and the way index.

A single command port carries three operations: lookup, fill and evict. Fills and evicts keep the filter counters in step with the lines held in each way. A per-result count of enabled full comparisons builds up in a counter, so that a test can measure how much comparison work the screening removes.

The controller has three states. ST_IDLE waits for a command. A lookup accepted in ST_IDLE or ST_MATCH moves it to ST_FILTER, where the screen is evaluated and registered. ST_FILTER always moves on to ST_MATCH, where the enabled full compares produce the result. From ST_MATCH the controller goes back to ST_FILTER on a new lookup and otherwise to ST_IDLE. Fill, evict and the no-operation code leave ST_IDLE in place and take ST_MATCH to ST_IDLE.

Top module: `ptl_way_lookup`

## Requirements
- R1: After reset, every line is invalid, every filter counter is zero, cmd_ready is 1, res_valid, hit and cmp_en are 0, and cmp_count is 0.
- R2: A lookup (cmd_op 2'b01) accepted at clock edge E gives cmd_ready=0 and res_valid=0 in the cycle after E, and res_valid=1 together with cmp_en, hit and hit_way for exactly the one cycle after edge E+1.
- R3: A command presented while cmd_ready is 0 is ignored: it changes no line and no filter counter.
- R4: A way whose filter counter in the lookup tag's slot is zero has its cmp_en bit at 0, even when its low tag bits match.
- R5: In the result cycle, cmp_en[w] is 1 exactly when way w's filter counter for the tag's slot is non-zero, the line of the requested set in way w is valid, and that line's tag bits [3:0] equal the lookup tag bits [3:0]. cmp_en is 0 outside the result cycle.
- R6: hit is 1 exactly when some way with cmp_en set holds a tag equal to all 20 lookup tag bits. hit_way is the lowest such way index, and it is 0 on a miss.
- R7: When no way passes the partial match, cmp_en is all zero and the result is a miss.
- R8: A fill (cmd_op 2'b10) writes cmd_tag into line (cmd_set, cmd_way) and marks it valid. It increments that way's counter for the new tag's slot and, if the line was already valid, decrements the counter for the old tag's slot.
- R9: An evict (cmd_op 2'b11) of a valid line clears it and decrements that way's counter for its tag's slot. An evict of an invalid line changes nothing.
- R10: cmp_count rises by the number of set cmp_en bits at the end of every result cycle, wraps at its width, and holds otherwise.
- R11: The filter slot of a tag is a 3-bit value whose bit k is the XOR of all tag bits i with i mod 3 = k.
- R12: The command code 2'b00 is a no-operation, and a fill or evict is accepted in ST_IDLE and in ST_MATCH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 00 none, 01 lookup, 10 fill, 11 evict |
| cmd_set | input | 4 | Set index |
| cmd_way | input | 2 | Way for fill or evict |
| cmd_tag | input | 20 | Tag for lookup or fill |
| cmd_ready | output | 1 | Command accepted this cycle if valid |
| cmp_en | output | 4 | Full-compare enable per way, result cycle only |
| res_valid | output | 1 | Lookup result present |
| hit | output | 1 | Lookup hit |
| hit_way | output | 2 | Way that hit |
| cmp_count | output | 16 | Running total of enabled full compares |

## Verification
A counter left non-zero after the line behind it is evicted or replaced does not show as a wrong hit. It shows as an extra cmp_en bit on the next lookup whose tag falls into that slot, and the same bit also makes cmp_count too large. A counter that reaches zero too early is more serious: it drops a way that really holds the tag, and the next lookup of that tag reports a miss in its result cycle, two edges after the lookup is accepted. A wrong stored tag or valid bit shows in the partial or full match of the first lookup that addresses that line. The scoreboard therefore checks every lookup result against a reference model, so each of these faults appears within one lookup of the event that caused it.

// File: rtl/ptl_pkg.sv
package ptl_pkg;

    typedef enum logic [1:0] {
        OP_NONE   = 2'b00,
        OP_LOOKUP = 2'b01,
        OP_FILL   = 2'b10,
        OP_EVICT  = 2'b11
    } ptl_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_FILTER = 2'b01,
        ST_MATCH  = 2'b10
    } ptl_state_e;

endpackage

// File: rtl/ptl_ctrl.sv
module ptl_ctrl
    import ptl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    output logic       cmd_ready,
    output logic       acc_lookup,
    output logic       acc_fill,
    output logic       acc_evict,
    output logic       in_filter,
    output logic       in_match
);

    ptl_state_e state_q;
    ptl_state_e state_d;
    ptl_op_e    op;

    assign op = ptl_op_e'(cmd_op);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid && op == OP_LOOKUP) begin
                    state_d = ST_FILTER;
                end
            end
            ST_FILTER: begin
                state_d = ST_MATCH;
            end
            ST_MATCH: begin
                if (cmd_valid && op == OP_LOOKUP) begin
                    state_d = ST_FILTER;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        cmd_ready  = 1'b0;
        in_filter  = 1'b0;
        in_match   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cmd_ready = 1'b1;
            end
            ST_FILTER: begin
                in_filter = 1'b1;
            end
            ST_MATCH: begin
                cmd_ready = 1'b1;
                in_match  = 1'b1;
            end
            default: begin
                cmd_ready = 1'b0;
            end
        endcase
        acc_lookup = cmd_ready && cmd_valid && (op == OP_LOOKUP);
        acc_fill   = cmd_ready && cmd_valid && (op == OP_FILL);
        acc_evict  = cmd_ready && cmd_valid && (op == OP_EVICT);
    end

endmodule

// File: rtl/ptl_tag_store.sv
module ptl_tag_store #(
    parameter int WAYS  = 4,
    parameter int SETS  = 16,
    parameter int TAG_W = 20,
    parameter int PT_W  = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_fill,
    input  logic             wr_evict,
    input  logic [SET_W-1:0] wr_set,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [TAG_W-1:0] wr_tag,
    output logic             old_valid,
    output logic [TAG_W-1:0] old_tag,
    input  logic [SET_W-1:0] rd_set,
    input  logic [TAG_W-1:0] rd_tag,
    output logic [WAYS-1:0]  part_hit,
    output logic [WAYS-1:0]  full_hit
);

    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic             vld_q [SETS][WAYS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    tag_q[s][w] <= '0;
                    vld_q[s][w] <= 1'b0;
                end
            end
        end else if (wr_fill) begin
            tag_q[wr_set][wr_way] <= wr_tag;
            vld_q[wr_set][wr_way] <= 1'b1;
        end else if (wr_evict) begin
            vld_q[wr_set][wr_way] <= 1'b0;
        end
    end

    assign old_valid = vld_q[wr_set][wr_way];
    assign old_tag   = tag_q[wr_set][wr_way];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign part_hit[w] = vld_q[rd_set][w] &&
                             (tag_q[rd_set][w][PT_W-1:0] == rd_tag[PT_W-1:0]);
        assign full_hit[w] = vld_q[rd_set][w] && (tag_q[rd_set][w] == rd_tag);
    end

endmodule

// File: rtl/ptl_filter_bank.sv
module ptl_filter_bank #(
    parameter int WAYS  = 4,
    parameter int SETS  = 16,
    parameter int TAG_W = 20,
    parameter int FH_W  = 3,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int FSLOTS = 1 << FH_W,
    localparam int FC_W   = $clog2(SETS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_en,
    input  logic [WAY_W-1:0] inc_way,
    input  logic [TAG_W-1:0] inc_tag,
    input  logic             dec_en,
    input  logic [WAY_W-1:0] dec_way,
    input  logic [TAG_W-1:0] dec_tag,
    input  logic [TAG_W-1:0] probe_tag,
    output logic [WAYS-1:0]  present
);

    function automatic logic [FH_W-1:0] slot_of(input logic [TAG_W-1:0] t);
        logic [FH_W-1:0] h;
        h = '0;
        for (int i = 0; i < TAG_W; i++) begin
            h[i % FH_W] = h[i % FH_W] ^ t[i];
        end
        return h;
    endfunction

    logic [FC_W-1:0] cnt_q [WAYS][FSLOTS];
    logic [FH_W-1:0] inc_slot;
    logic [FH_W-1:0] dec_slot;
    logic [FH_W-1:0] probe_slot;

    assign inc_slot   = slot_of(inc_tag);
    assign dec_slot   = slot_of(dec_tag);
    assign probe_slot = slot_of(probe_tag);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WAYS; w++) begin
                for (int s = 0; s < FSLOTS; s++) begin
                    cnt_q[w][s] <= '0;
                end
            end
        end else begin
            for (int w = 0; w < WAYS; w++) begin
                for (int s = 0; s < FSLOTS; s++) begin
                    logic up;
                    logic dn;
                    up = inc_en && (inc_way == WAY_W'(w)) && (inc_slot == FH_W'(s));
                    dn = dec_en && (dec_way == WAY_W'(w)) && (dec_slot == FH_W'(s));
                    if (up && !dn) begin
                        cnt_q[w][s] <= cnt_q[w][s] + 1'b1;
                    end else if (dn && !up) begin
                        cnt_q[w][s] <= cnt_q[w][s] - 1'b1;
                    end
                end
            end
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_probe
        assign present[w] = (cnt_q[w][probe_slot] != '0);
    end

endmodule

// File: rtl/ptl_way_lookup.sv
module ptl_way_lookup #(
    parameter int WAYS   = 4,
    parameter int SETS   = 16,
    parameter int TAG_W  = 20,
    parameter int PT_W   = 4,
    parameter int FH_W   = 3,
    parameter int CCNT_W = 16,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [SET_W-1:0]  cmd_set,
    input  logic [WAY_W-1:0]  cmd_way,
    input  logic [TAG_W-1:0]  cmd_tag,
    output logic              cmd_ready,
    output logic [WAYS-1:0]   cmp_en,
    output logic              res_valid,
    output logic              hit,
    output logic [WAY_W-1:0]  hit_way,
    output logic [CCNT_W-1:0] cmp_count
);

    logic             acc_lookup;
    logic             acc_fill;
    logic             acc_evict;
    logic             in_filter;
    logic             in_match;
    logic             old_valid;
    logic [TAG_W-1:0] old_tag;
    logic [WAYS-1:0]  part_hit;
    logic [WAYS-1:0]  full_hit;
    logic [WAYS-1:0]  present;
    logic [WAYS-1:0]  screen_d;
    logic [WAYS-1:0]  screen_q;
    logic [WAYS-1:0]  win;
    logic [SET_W-1:0] req_set;
    logic [TAG_W-1:0] req_tag;

    ptl_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_ready  (cmd_ready),
        .acc_lookup (acc_lookup),
        .acc_fill   (acc_fill),
        .acc_evict  (acc_evict),
        .in_filter  (in_filter),
        .in_match   (in_match)
    );

    ptl_tag_store #(
        .WAYS  (WAYS),
        .SETS  (SETS),
        .TAG_W (TAG_W),
        .PT_W  (PT_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_fill   (acc_fill),
        .wr_evict  (acc_evict),
        .wr_set    (cmd_set),
        .wr_way    (cmd_way),
        .wr_tag    (cmd_tag),
        .old_valid (old_valid),
        .old_tag   (old_tag),
        .rd_set    (req_set),
        .rd_tag    (req_tag),
        .part_hit  (part_hit),
        .full_hit  (full_hit)
    );

    ptl_filter_bank #(
        .WAYS  (WAYS),
        .SETS  (SETS),
        .TAG_W (TAG_W),
        .FH_W  (FH_W)
    ) u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_en    (acc_fill),
        .inc_way   (cmd_way),
        .inc_tag   (cmd_tag),
        .dec_en    ((acc_fill || acc_evict) && old_valid),
        .dec_way   (cmd_way),
        .dec_tag   (old_tag),
        .probe_tag (req_tag),
        .present   (present)
    );

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_set <= '0;
            req_tag <= '0;
        end else if (acc_lookup) begin
            req_set <= cmd_set;
            req_tag <= cmd_tag;
        end
    end

    // stage one: filter then partial tag
    assign screen_d = present & part_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            screen_q <= '0;
        end else if (in_filter) begin
            screen_q <= screen_d;
        end
    end

    // stage two: enabled full compares only
    assign cmp_en    = in_match ? screen_q : '0;
    assign win       = cmp_en & full_hit;
    assign res_valid = in_match;
    assign hit       = |win;

    always_comb begin
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (win[w]) begin
                hit_way = WAY_W'(w);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_count <= '0;
        end else if (in_match) begin
            cmp_count <= cmp_count + CCNT_W'($countones(cmp_en));
        end
    end

endmodule

// File: rtl/ptl_way_lookup_chk.sv
module ptl_way_lookup_chk #(
    parameter int WAYS   = 4,
    parameter int WAY_W  = 2,
    parameter int CCNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic              cmd_ready,
    input logic [WAYS-1:0]   cmp_en,
    input logic              res_valid,
    input logic              hit,
    input logic [WAY_W-1:0]  hit_way,
    input logic [CCNT_W-1:0] cmp_count
);

    AST_LOOKUP_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == 2'b01) |=> (!cmd_ready && !res_valid)); // R2

    AST_STALL_THEN_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready |=> res_valid); // R2

    AST_RESULT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R2

    AST_EN_IN_RESULT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (cmp_en == '0)); // R5

    AST_HIT_HAS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (res_valid && cmp_en[hit_way])); // R6

    AST_MISS_WAY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !hit) |-> (hit_way == '0)); // R6

    AST_NO_ENABLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en == '0) |-> !hit); // R7

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (cmp_count == $past(cmp_count) + CCNT_W'($countones($past(cmp_en))))); // R10

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(cmp_count)); // R10

endmodule

bind ptl_way_lookup ptl_way_lookup_chk #(
    .WAYS   (WAYS),
    .WAY_W  (WAY_W),
    .CCNT_W (CCNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_ready (cmd_ready),
    .cmp_en    (cmp_en),
    .res_valid (res_valid),
    .hit       (hit),
    .hit_way   (hit_way),
    .cmp_count (cmp_count)
);

// File: tb/tb_ptl_way_lookup.sv
module tb_ptl_way_lookup;

    localparam int WAYS = 4;
    localparam int SETS = 16;

    logic        clk;
    logic        rst_n;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [3:0]  cmd_set;
    logic [1:0]  cmd_way;
    logic [19:0] cmd_tag;
    logic        cmd_ready;
    logic [3:0]  cmp_en;
    logic        res_valid;
    logic        hit;
    logic [1:0]  hit_way;
    logic [15:0] cmp_count;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    ptl_way_lookup dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_set   (cmd_set),
        .cmd_way   (cmd_way),
        .cmd_tag   (cmd_tag),
        .cmd_ready (cmd_ready),
        .cmp_en    (cmp_en),
        .res_valid (res_valid),
        .hit       (hit),
        .hit_way   (hit_way),
        .cmp_count (cmp_count)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    // reference model
    logic [19:0] m_tag [SETS][WAYS];
    bit          m_vld [SETS][WAYS];
    int          m_cnt [WAYS][8];
    int          exp_count = 0;

    typedef struct packed {
        logic [3:0] en;
        logic       hit;
        logic [1:0] way;
    } exp_t;

    exp_t exp_q[$];

    function automatic int slot(input logic [19:0] t);
        int r = 0;
        for (int b = 0; b < 3; b++) begin
            logic x = 1'b0;
            for (int i = b; i < 20; i += 3) x ^= t[i];
            if (x) r += (1 << b);
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic send(input logic [1:0] op, input int s, input int w, input logic [19:0] t);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_set   = 4'(s);
        cmd_way   = 2'(w);
        cmd_tag   = t;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 2'b00;
    endtask

    task automatic do_fill(input int s, input int w, input logic [19:0] t); // R8
        if (m_vld[s][w]) m_cnt[w][slot(m_tag[s][w])]--;
        m_cnt[w][slot(t)]++;
        m_tag[s][w] = t;
        m_vld[s][w] = 1;
        send(2'b10, s, w, t);
    endtask

    task automatic do_evict(input int s, input int w); // R9
        if (m_vld[s][w]) begin
            m_cnt[w][slot(m_tag[s][w])]--;
            m_vld[s][w] = 0;
        end
        send(2'b11, s, w, 20'h0);
    endtask

    function automatic exp_t predict(input int s, input logic [19:0] t);
        exp_t e;
        e = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            e.en[w] = (m_cnt[w][slot(t)] != 0) && m_vld[s][w] && (m_tag[s][w][3:0] == t[3:0]);
            if (e.en[w] && m_tag[s][w] == t) begin
                e.hit = 1'b1;
                e.way = 2'(w);
            end
        end
        return e;
    endfunction

    // issue lookup; optional intruding fill during the stall cycle (R3)
    task automatic do_lookup_x(input int s, input logic [19:0] t, input bit intrude,
                               input int is, input int iw, input logic [19:0] it);
        exp_q.push_back(predict(s, t));
        send(2'b01, s, 0, t);
        check(cmd_ready == 1'b0, "R2 ready low in filter cycle", cmd_ready, 0);
        check(res_valid == 1'b0, "R2 no result in filter cycle", res_valid, 0);
        if (intrude) begin
            cmd_valid = 1'b1;
            cmd_op    = 2'b10;
            cmd_set   = 4'(is);
            cmd_way   = 2'(iw);
            cmd_tag   = it;
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 2'b00;
    endtask

    task automatic do_lookup(input int s, input logic [19:0] t);
        do_lookup_x(s, t, 1'b0, 0, 0, 20'h0);
    endtask

    // monitor: scoreboard compare in result cycle
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(cmp_en == e.en, "R5 cmp_en per way (R4 filter, R7 partial)", cmp_en, e.en);
                check(hit == e.hit, "R6 hit", hit, e.hit);
                check(hit_way == e.way, "R6 hit_way", hit_way, e.way);
                check(cmp_count == 16'(exp_count), "R10 cmp_count", cmp_count, exp_count);
                exp_count += $countones(e.en);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_tag[s][w] = '0;
                m_vld[s][w] = 0;
            end
        for (int w = 0; w < WAYS; w++)
            for (int k = 0; k < 8; k++) m_cnt[w][k] = 0;
        rst_n     = 1'b0;
        cmd_valid = 1'b0;
        cmd_op    = 2'b00;
        cmd_set   = '0;
        cmd_way   = '0;
        cmd_tag   = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
        check(res_valid == 1'b0, "R1 res_valid", res_valid, 0);
        check(cmp_en == 4'h0, "R1 cmp_en", cmp_en, 0);
        check(hit == 1'b0, "R1 hit", hit, 0);
        check(cmp_count == 16'h0, "R1 cmp_count", cmp_count, 0);
        do_lookup(3, 20'h12345);                 // R1 empty: all filtered

        // R8 fill then hit; R12 no-op ignored
        do_fill(3, 1, 20'h12345);
        send(2'b00, 3, 2, 20'h99999);             // R12 no-op
        do_lookup(3, 20'h12345);
        do_fill(3, 2, 20'hABCD5);
        do_lookup(3, 20'h12345);
        // R4 filter false positive from another set, same way
        do_fill(7, 2, 20'h12345);
        do_lookup(3, 20'h12345);
        // R4 filter drop: partial match, slot empty (R11 slot mapping)
        do_lookup(3, 20'hABCC5);
        // R7 no partial match
        do_lookup(3, 20'h12346);
        // R8 replace decrements old slot
        do_fill(3, 1, 20'h55555);
        do_lookup(3, 20'h12345);
        do_lookup(3, 20'h55555);
        // R9 evict valid, then evict invalid (no effect)
        do_evict(3, 1);
        do_lookup(3, 20'h55555);
        do_evict(3, 1);
        do_lookup(7, 20'h12345);
        do_lookup(3, 20'hABCD5);
        // R3 fill during filter cycle is ignored
        do_lookup_x(7, 20'h12345, 1'b1, 5, 0, 20'h00009);
        do_lookup(5, 20'h00009);

        // multi-way sets, shared low nibble
        for (int k = 0; k < 8; k++) begin
            for (int w = 0; w < WAYS; w++) begin
                logic [19:0] t = 20'((k * 32'h1F3A7 + w * 32'h0F011) << 4) | 20'hA;
                do_fill(8 + k, w, t);
            end
            for (int w = 0; w < WAYS; w++) do_lookup(8 + k, m_tag[8 + k][w]);
            do_lookup(8 + k, 20'hFFFFA ^ 20'(k << 8));
            do_evict(8 + k, k % WAYS);
            do_lookup(8 + k, m_tag[8 + k][(k + 1) % WAYS]);
        end

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R2 every lookup produced a result", exp_q.size(), 0);
        check(cmp_count == 16'(exp_count), "R10 final cmp_count", cmp_count, exp_count);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule